// File: doc/BRIEF.md
# Attributed Store Dispatch Unit

This unit sits between a core's store issue stage and the memory hierarchy. It takes stores one at a time, in the order the core issues them. Each store carries an address, a data word and two attribute flags. The flags decide where the store has to land before it counts as done.

A store with neither flag is written into the top-level cache and nothing more. A store with the uncached flag skips the caches and sends exactly one request to the memory or device controller. A store with the ordering flag is written into the cache. It is then chased by a run of evictions of its line, one per cache level, down to the coherence level. It completes when that level acknowledges. A store with both flags does the ordering sequence first and then sends the controller request.

A trap input freezes all outgoing traffic. The pending store stays where it is and resumes when the trap clears, so nothing is issued twice. The unit accepts the next store only after the current one has finished. This keeps every destination in issue order.

Top module: `store_dispatch_unit`

## Requirements
- R1: After reset the unit shows `reqReady` high with all three outgoing valids low. `reqReady` is high only while no store is in progress.
- R2: A store with both flags clear produces exactly one cache write carrying its address and data. It produces no controller request and no eviction.
- R3: A store with only `reqUncached` set produces exactly one controller request carrying its address and data. It produces no cache write and no eviction.
- R4: A store with `reqOrdering` set first produces one cache write. It then produces `EVICT_STEPS` evictions of line `addr >> LINE_BITS`, with `evictLevel` counting 0, 1, … up to `EVICT_STEPS-1`. It then waits for a `cohAck` pulse, and the unit stays busy until that pulse arrives.
- R5: A store with both flags set runs the full R4 sequence, including the `cohAck` wait, and then produces exactly one controller request.
- R6: While `trapHold` is high, all outgoing valids are low. The held store resumes when the trap clears and issues each of its remaining operations exactly once.
- R7: No store is accepted while another is in progress. All outgoing operations appear in the order their stores were accepted.
- R8: While an outgoing valid is high and its ready is low, that port's address, data and level stay unchanged.
- R9: At most one of `cacheWrValid`, `ctrlValid` and `evictValid` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Store request present |
| reqReady | output | 1 | Unit can accept a store |
| reqAddr | input | ADDR_W | Store byte address |
| reqData | input | DATA_W | Store data |
| reqUncached | input | 1 | Route the store to the controller and bypass the caches |
| reqOrdering | input | 1 | Force the line down to the coherence level after the cache write |
| trapHold | input | 1 | Freeze all outgoing traffic for a trap |
| cacheWrValid | output | 1 | Top-level cache write request |
| cacheWrReady | input | 1 | Cache accepts the write |
| cacheWrAddr | output | ADDR_W | Cache write address |
| cacheWrData | output | DATA_W | Cache write data |
| ctrlValid | output | 1 | Controller request |
| ctrlReady | input | 1 | Controller accepts the request |
| ctrlAddr | output | ADDR_W | Controller request address |
| ctrlData | output | DATA_W | Controller request data |
| evictValid | output | 1 | Eviction request |
| evictReady | input | 1 | Eviction accepted |
| evictAddr | output | ADDR_W-LINE_BITS | Line address being evicted |
| evictLevel | output | LVL_W | Cache level being evicted, 0 = top |
| cohAck | input | 1 | Coherence level has received the line (one-cycle pulse) |

## Verification
Directed stores, one of each flag combination with every ready held high, check the four routing paths in isolation: cache only, controller only, eviction chain, and eviction chain followed by the controller request. A directed uncached store arrives during a long trap. It shows whether the held request is issued once after the trap or leaks out early. Random stores are then sent back to back, with random addresses, data, flags, ready stalls, trap windows and delayed acknowledges. The bench compares every handshake against a per-store list of expected operations. This exposes reordering, duplication, missing evictions, wrong levels, a controller request sent before the acknowledge, and acceptance of a store while another is still in progress.

// File: rtl/store_dispatch_pkg.sv
package store_dispatch_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CACHE = 3'd1,
    ST_EVICT = 3'd2,
    ST_ACK   = 3'd3,
    ST_CTRL  = 3'd4
  } dispState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch incoming request
    logic levelClr;  // restart eviction level count
    logic levelInc;  // advance to next level
  } dpStrobe_t;

endpackage

// File: rtl/store_dispatch_datapath.sv
module store_dispatch_datapath
  import store_dispatch_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int LINE_BITS   = 6,
  parameter int EVICT_STEPS = 2,
  localparam int LINE_W     = ADDR_W - LINE_BITS,
  localparam int LVL_W      = (EVICT_STEPS > 1) ? $clog2(EVICT_STEPS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic              reqUncached,
  input  logic              reqOrdering,
  output logic [ADDR_W-1:0] heldAddr,
  output logic [DATA_W-1:0] heldData,
  output logic [LINE_W-1:0] heldLine,
  output logic              heldUncached,
  output logic              heldOrdering,
  output logic [LVL_W-1:0]  level,
  output logic              levelLast
);

  localparam logic [LVL_W-1:0] LAST_LEVEL = LVL_W'(EVICT_STEPS - 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldAddr     <= '0;
      heldData     <= '0;
      heldUncached <= 1'b0;
      heldOrdering <= 1'b0;
    end else if (strobe.capture) begin
      heldAddr     <= reqAddr;
      heldData     <= reqData;
      heldUncached <= reqUncached;
      heldOrdering <= reqOrdering;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                level <= '0;
    else if (strobe.levelClr) level <= '0;
    else if (strobe.levelInc) level <= level + 1'b1;
  end

  assign heldLine  = heldAddr[ADDR_W-1:LINE_BITS];
  assign levelLast = (level == LAST_LEVEL);

endmodule

// File: rtl/store_dispatch_ctrl.sv
module store_dispatch_ctrl
  import store_dispatch_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqUncached,
  input  logic      reqOrdering,
  input  logic      heldUncached,
  input  logic      heldOrdering,
  input  logic      levelLast,
  input  logic      trapHold,
  input  logic      cacheWrReady,
  input  logic      ctrlReady,
  input  logic      evictReady,
  input  logic      cohAck,
  output logic      reqReady,
  output logic      cacheWrValid,
  output logic      ctrlValid,
  output logic      evictValid,
  output dpStrobe_t strobe
);

  dispState_t state, stateNext;
  logic accept, cacheFire, ctrlFire, evictFire;

  assign reqReady     = (state == ST_IDLE);
  assign cacheWrValid = (state == ST_CACHE) && !trapHold;
  assign ctrlValid    = (state == ST_CTRL)  && !trapHold;
  assign evictValid   = (state == ST_EVICT) && !trapHold;

  assign accept    = reqValid && reqReady;
  assign cacheFire = cacheWrValid && cacheWrReady;
  assign ctrlFire  = ctrlValid && ctrlReady;
  assign evictFire = evictValid && evictReady;

  always_comb begin
    stateNext       = state;
    strobe          = '0;
    strobe.capture  = accept;
    strobe.levelClr = accept;
    unique case (state)
      ST_IDLE: begin
        if (accept) begin
          if (reqUncached && !reqOrdering) stateNext = ST_CTRL;
          else                             stateNext = ST_CACHE;
        end
      end
      ST_CACHE: begin
        if (cacheFire) stateNext = heldOrdering ? ST_EVICT : ST_IDLE;
      end
      ST_EVICT: begin
        if (evictFire) begin
          if (levelLast) stateNext = ST_ACK;
          else           strobe.levelInc = 1'b1;
        end
      end
      ST_ACK: begin
        if (cohAck) stateNext = heldUncached ? ST_CTRL : ST_IDLE;
      end
      ST_CTRL: begin
        if (ctrlFire) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/store_dispatch_unit.sv
module store_dispatch_unit
  import store_dispatch_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int LINE_BITS   = 6,
  parameter int EVICT_STEPS = 2,
  localparam int LINE_W     = ADDR_W - LINE_BITS,
  localparam int LVL_W      = (EVICT_STEPS > 1) ? $clog2(EVICT_STEPS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic              reqUncached,
  input  logic              reqOrdering,
  input  logic              trapHold,
  output logic              cacheWrValid,
  input  logic              cacheWrReady,
  output logic [ADDR_W-1:0] cacheWrAddr,
  output logic [DATA_W-1:0] cacheWrData,
  output logic              ctrlValid,
  input  logic              ctrlReady,
  output logic [ADDR_W-1:0] ctrlAddr,
  output logic [DATA_W-1:0] ctrlData,
  output logic              evictValid,
  input  logic              evictReady,
  output logic [LINE_W-1:0] evictAddr,
  output logic [LVL_W-1:0]  evictLevel,
  input  logic              cohAck
);

  dpStrobe_t         strobe;
  logic [ADDR_W-1:0] heldAddr;
  logic [DATA_W-1:0] heldData;
  logic [LINE_W-1:0] heldLine;
  logic              heldUncached, heldOrdering, levelLast;
  logic [LVL_W-1:0]  level;

  store_dispatch_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqUncached(reqUncached), .reqOrdering(reqOrdering),
    .heldUncached(heldUncached), .heldOrdering(heldOrdering),
    .levelLast(levelLast), .trapHold(trapHold),
    .cacheWrReady(cacheWrReady), .ctrlReady(ctrlReady),
    .evictReady(evictReady), .cohAck(cohAck),
    .reqReady(reqReady), .cacheWrValid(cacheWrValid),
    .ctrlValid(ctrlValid), .evictValid(evictValid), .strobe(strobe)
  );

  store_dispatch_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .LINE_BITS(LINE_BITS), .EVICT_STEPS(EVICT_STEPS)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqAddr(reqAddr), .reqData(reqData),
    .reqUncached(reqUncached), .reqOrdering(reqOrdering),
    .heldAddr(heldAddr), .heldData(heldData), .heldLine(heldLine),
    .heldUncached(heldUncached), .heldOrdering(heldOrdering),
    .level(level), .levelLast(levelLast)
  );

  assign cacheWrAddr = heldAddr;
  assign cacheWrData = heldData;
  assign ctrlAddr    = heldAddr;
  assign ctrlData    = heldData;
  assign evictAddr   = heldLine;
  assign evictLevel  = level;

endmodule

// File: rtl/store_dispatch_chk.sv
module store_dispatch_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINE_W = 26,
  parameter int LVL_W  = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              trapHold,
  input logic              cacheWrValid,
  input logic              cacheWrReady,
  input logic [ADDR_W-1:0] cacheWrAddr,
  input logic [DATA_W-1:0] cacheWrData,
  input logic              ctrlValid,
  input logic              ctrlReady,
  input logic [ADDR_W-1:0] ctrlAddr,
  input logic [DATA_W-1:0] ctrlData,
  input logic              evictValid,
  input logic              evictReady,
  input logic [LINE_W-1:0] evictAddr,
  input logic [LVL_W-1:0]  evictLevel
);

  // R1
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !(cacheWrValid || ctrlValid || evictValid));

  // R7
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R6
  trap_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    trapHold |-> !(cacheWrValid || ctrlValid || evictValid));

  // R9
  one_port_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cacheWrValid, ctrlValid, evictValid}));

  // R2
  single_cache_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cacheWrValid && cacheWrReady) |=> !cacheWrValid);

  // R3
  single_ctrl_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlValid && ctrlReady) |=> !ctrlValid);

  // R4
  level_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evictValid && evictReady) |=>
      (!evictValid || evictLevel == $past(evictLevel) + 1'b1));

  // R8
  cache_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cacheWrValid && !cacheWrReady) |=> ($stable(cacheWrAddr) && $stable(cacheWrData)));

  // R8
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlValid && !ctrlReady) |=> ($stable(ctrlAddr) && $stable(ctrlData)));

  // R8
  evict_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evictValid && !evictReady) |=> ($stable(evictAddr) && $stable(evictLevel)));

endmodule

bind store_dispatch_unit store_dispatch_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_W(LINE_W), .LVL_W(LVL_W)
) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .trapHold(trapHold),
  .cacheWrValid(cacheWrValid), .cacheWrReady(cacheWrReady),
  .cacheWrAddr(cacheWrAddr), .cacheWrData(cacheWrData),
  .ctrlValid(ctrlValid), .ctrlReady(ctrlReady),
  .ctrlAddr(ctrlAddr), .ctrlData(ctrlData),
  .evictValid(evictValid), .evictReady(evictReady),
  .evictAddr(evictAddr), .evictLevel(evictLevel)
);

// File: tb/store_dispatch_unit_tb_top.sv
module store_dispatch_unit_tb_top;

  localparam int ADDR_W      = 32;
  localparam int DATA_W      = 32;
  localparam int LINE_BITS   = 6;
  localparam int EVICT_STEPS = 2;
  localparam int LINE_W      = ADDR_W - LINE_BITS;
  localparam int LVL_W       = 1;
  localparam int NUM_RANDOM  = 300;

  // expected operation kinds
  localparam int K_CACHE = 0;
  localparam int K_EVICT = 1;
  localparam int K_ACK   = 2;
  localparam int K_CTRL  = 3;

  typedef struct {
    int          kind;
    logic [31:0] addr;
    logic [31:0] data;
    int          lvl;
    string       req;
  } expOp_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqReady;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqData = '0;
  logic reqUncached = 1'b0, reqOrdering = 1'b0;
  logic trapHold = 1'b0;
  logic cacheWrValid, cacheWrReady = 1'b1;
  logic [ADDR_W-1:0] cacheWrAddr;
  logic [DATA_W-1:0] cacheWrData;
  logic ctrlValid, ctrlReady = 1'b1;
  logic [ADDR_W-1:0] ctrlAddr;
  logic [DATA_W-1:0] ctrlData;
  logic evictValid, evictReady = 1'b1;
  logic [LINE_W-1:0] evictAddr;
  logic [LVL_W-1:0]  evictLevel;
  logic cohAck = 1'b0;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  bit finished = 1'b0;
  bit ackPend = 1'b0;
  int readyPct = 100;
  int trapPct = 0;
  bit forceTrap = 1'b0;
  expOp_t expQ[$];

  always #10 clk = ~clk;   // 50 MHz

  store_dispatch_unit #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .LINE_BITS(LINE_BITS), .EVICT_STEPS(EVICT_STEPS)
  ) dut_i (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqData(reqData),
    .reqUncached(reqUncached), .reqOrdering(reqOrdering),
    .trapHold(trapHold),
    .cacheWrValid(cacheWrValid), .cacheWrReady(cacheWrReady),
    .cacheWrAddr(cacheWrAddr), .cacheWrData(cacheWrData),
    .ctrlValid(ctrlValid), .ctrlReady(ctrlReady),
    .ctrlAddr(ctrlAddr), .ctrlData(ctrlData),
    .evictValid(evictValid), .evictReady(evictReady),
    .evictAddr(evictAddr), .evictLevel(evictLevel),
    .cohAck(cohAck)
  );

  function automatic string kindName(int k);
    case (k)
      K_CACHE: return "cache";
      K_EVICT: return "evict";
      K_ACK:   return "ack";
      default: return "ctrl";
    endcase
  endfunction

  // expected operation list for one store, from R2..R5
  function automatic void pushExpected(logic [31:0] a, logic [31:0] d, logic u, logic o);
    expOp_t e;
    string r;
    r = (u && o) ? "R5" : (o ? "R4" : (u ? "R3" : "R2"));
    e.addr = a; e.data = d; e.lvl = 0; e.req = r;
    if (!u || o) begin e.kind = K_CACHE; expQ.push_back(e); end
    if (o) begin
      for (int i = 0; i < EVICT_STEPS; i++) begin
        e.kind = K_EVICT; e.addr = a >> LINE_BITS; e.lvl = i; expQ.push_back(e);
      end
      e.kind = K_ACK; e.addr = a; e.lvl = 0; expQ.push_back(e);
    end
    if (u) begin e.kind = K_CTRL; e.addr = a; e.lvl = 0; expQ.push_back(e); end
  endfunction

  task automatic observe(int k, logic [31:0] a, logic [31:0] d, int l);
    expOp_t e;
    vectors++;
    if (expQ.size() == 0) begin
      miscompares++;
      $display("FAIL R7 unexpected %s op addr=%h: actual op present, expected none",
               kindName(k), a);
      return;
    end
    e = expQ.pop_front();
    if (e.kind != k || (k != K_ACK && (e.addr != a ||
        (k != K_EVICT && e.data != d) || (k == K_EVICT && e.lvl != l)))) begin
      miscompares++;
      $display("FAIL %s actual %s a=%h d=%h l=%0d expected %s a=%h d=%h l=%0d",
               e.req, kindName(k), a, d, l, kindName(e.kind), e.addr, e.data, e.lvl);
    end
    if (expQ.size() != 0 && expQ[0].kind == K_ACK && k == K_EVICT) ackPend = 1'b1;
  endtask

  // monitor: samples mid-cycle, before the next edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (trapHold && (cacheWrValid || ctrlValid || evictValid)) begin
        vectors++; miscompares++;
        $display("FAIL R6 valid during trap: actual c=%b x=%b e=%b expected all 0",
                 cacheWrValid, ctrlValid, evictValid);
      end
      if (cacheWrValid && cacheWrReady) observe(K_CACHE, cacheWrAddr, cacheWrData, 0);
      if (evictValid && evictReady)
        observe(K_EVICT, 32'(evictAddr), '0, int'(evictLevel));
      if (cohAck) observe(K_ACK, '0, '0, 0);
      if (ctrlValid && ctrlReady) observe(K_CTRL, ctrlAddr, ctrlData, 0);
      if (reqValid && reqReady) begin
        vectors++;
        if (expQ.size() != 0) begin
          miscompares++;
          $display("FAIL R7 accepted while busy: actual %0d ops outstanding, expected 0",
                   expQ.size());
        end
        pushExpected(reqAddr, reqData, reqUncached, reqOrdering);
      end
    end
  end

  // downstream responders, driven just after the edge
  always @(posedge clk) begin
    #2;
    cacheWrReady = ($urandom_range(99) < readyPct);
    ctrlReady    = ($urandom_range(99) < readyPct);
    evictReady   = ($urandom_range(99) < readyPct);
    trapHold     = forceTrap || ($urandom_range(99) < trapPct);
    if (cohAck) cohAck = 1'b0;
    else if (ackPend && $urandom_range(1) == 1) begin
      cohAck = 1'b1; ackPend = 1'b0;
    end
  end

  task automatic doStore(logic [31:0] a, logic [31:0] d, logic u, logic o);
    @(posedge clk); #3;
    reqValid = 1'b1; reqAddr = a; reqData = d; reqUncached = u; reqOrdering = o;
    forever begin
      @(negedge clk);
      if (reqReady) break;
    end
    @(posedge clk); #3;
    reqValid = 1'b0;
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic finish();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
      finish();
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #3 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    vectors++;
    if (!(reqReady && !cacheWrValid && !ctrlValid && !evictValid)) begin
      miscompares++;
      $display("FAIL R1 reset: actual rdy=%b c=%b x=%b e=%b expected 1 0 0 0",
               reqReady, cacheWrValid, ctrlValid, evictValid);
    end

    // directed: one per flag combination (R2, R3, R4, R5)
    doStore(32'h0000_1040, 32'hAAAA_0001, 1'b0, 1'b0); drain();
    doStore(32'h8000_0010, 32'hBBBB_0002, 1'b1, 1'b0); drain();
    doStore(32'h0000_2FC4, 32'hCCCC_0003, 1'b0, 1'b1); drain();
    doStore(32'hFFFF_FFC0, 32'hDDDD_0004, 1'b1, 1'b1); drain();

    // directed R6: uncached store held by a long trap
    @(posedge clk); #3 forceTrap = 1'b1;
    doStore(32'h4000_0100, 32'hEEEE_0005, 1'b1, 1'b0);
    repeat (6) @(negedge clk);
    vectors++;
    if (expQ.size() != 1) begin
      miscompares++;
      $display("FAIL R6 store leaked through trap: actual %0d pending, expected 1",
               expQ.size());
    end
    @(posedge clk); #3 forceTrap = 1'b0;
    drain();

    // directed R4: ack delayed by back-pressure on evicts
    readyPct = 30;
    doStore(32'h0000_0000, 32'h1234_5678, 1'b0, 1'b1); drain();

    // random back-to-back stores with stalls and traps (R7, R8)
    readyPct = 60; trapPct = 15;
    for (int n = 0; n < NUM_RANDOM; n++) begin
      doStore($urandom, $urandom, 1'($urandom_range(1)), 1'($urandom_range(1)));
    end
    drain();

    // R7 nothing left over
    vectors++;
    if (expQ.size() != 0) begin
      miscompares++;
      $display("FAIL R7 leftover ops: actual %0d, expected 0", expQ.size());
    end
    finish();
  end

endmodule